// File: doc/BRIEF.md
# Next-Fetch-Address Predictor with Selectable Direction Scheme

The block sits in the fetch stage. In each cycle it looks up the current fetch PC in a small direct-mapped target buffer, all combinationally. It returns the predicted next fetch PC, a flag saying the fetched word is a known branch, and a flag saying that branch is predicted taken. Each buffer entry holds four things: the target recorded the last time the branch was taken, a backward bit worked out when the entry is written, the compiler hint bit captured when the entry is allocated, and the outcome of the most recent resolve.

A mode input chooses which of these direction sources steers fetch. The choices are: never redirect, redirect on every hit, redirect backward hits only, follow the stored hint, or follow the last outcome. The execute stage reports each resolved branch on the resolve port, together with the next PC that fetch predicted for that branch. The block uses this report to update or allocate the entry. When the prediction was wrong it pulses a mispredict flag and increments a saturating counter.

Top module: `nfp_predictor`

## Requirements
- R1: After reset every lookup misses. On a miss the branch flag is low, the taken flag is low and the predicted PC is fetch PC + 4.
- R2: Mode code 0 (never-taken) ignores the buffer. The predicted PC is fetch PC + 4 and both flags are low, even on a hit. Codes 5 to 7 behave like code 0.
- R3: Mode code 1 (always-taken) predicts taken on every hit. The predicted PC is then the stored target and both flags are high.
- R4: Mode code 2 (backward-taken) predicts taken only when the stored target is strictly lower than the branch PC. A forward hit raises the branch flag but predicts PC + 4.
- R5: Mode code 3 (hint) predicts the hint bit that was stored when the entry was allocated. Later resolves of the same branch never change that bit.
- R6: Mode code 4 (last-time) predicts the direction of the most recent resolve of that entry. A strictly alternating outcome pattern is therefore mispredicted on every resolve.
- R7: A resolve that is not taken and misses in the buffer installs nothing. The PC still misses afterwards, and the entry already at that index is unchanged.
- R8: A taken resolve that misses allocates its entry and replaces any entry with a different tag at the same index (index = PC[5:2], tag = PC[31:6]). The last-outcome bit of the new entry is taken.
- R9: A taken resolve that hits overwrites the stored target and recomputes the backward bit from the new target.
- R10: In the cycle after a resolve, mispredict_o is high exactly when the actual next PC (target if taken, else PC + 4) differs from the reported prediction. In every other cycle it is low.
- R11: The mispredict counter increments once per mispredict pulse and saturates at 65535.
- R12: A lookup and an update to the same entry in the same cycle return the contents the entry had before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Direction scheme select (codes per R2 to R6) |
| fetch_pc_i | input | 32 | Current fetch PC |
| pred_pc_o | output | 32 | Predicted next fetch PC |
| pred_branch_o | output | 1 | Fetch PC hit a buffer entry (scheme uses the buffer) |
| pred_taken_o | output | 1 | Predicted taken |
| res_valid_i | input | 1 | Resolve report valid |
| res_pc_i | input | 32 | PC of the resolved branch |
| res_target_i | input | 32 | Computed target of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_hint_i | input | 1 | Compiler hint bit of the branch |
| res_pred_pc_i | input | 32 | Next PC that was predicted for this branch |
| mispredict_o | output | 1 | One-cycle mispredict pulse |
| mispred_cnt_o | output | 16 | Saturating mispredict count |

## Verification
The assertions assume that mode_i is steady during a lookup that is being judged. They also assume that resolve reports arrive at most once per cycle and only for word-aligned PCs. The stimulus obeys both rules: it changes inputs only on the falling edge, and it builds every PC as a multiple of four. The prediction a resolve carries is the value the bench's own model predicts, or a deliberately wrong value when the bench wants a mispredict. Held-valid resolve bursts are used only for not-taken misses, and these must leave the buffer untouched.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
  parameter int PC_W = 32;

  typedef enum logic [2:0] {
    M_NEVER  = 3'd0,
    M_ALWAYS = 3'd1,
    M_BACK   = 3'd2,
    M_HINT   = 3'd3,
    M_LAST   = 3'd4
  } dir_mode_e;

  typedef struct packed {
    logic [PC_W-1:0] target;
    logic            bwd;
    logic            hint;
    logic            last;
  } btb_ent_t;
endpackage

// File: rtl/nfp_btb.sv
module nfp_btb import nfp_pkg::*; #(
  parameter int IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            rd_hit_o,
  output btb_ent_t        rd_ent_o,
  input  logic            wr_en_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [PC_W-1:0] wr_target_i,
  input  logic            wr_taken_i,
  input  logic            wr_hint_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  btb_ent_t           ent_q [ENTRIES];

  logic [IDX_W-1:0] ridx, widx;
  logic [TAG_W-1:0] rtag, wtag;
  logic             wr_hit;

  assign ridx = rd_pc_i[IDX_W+1:2];
  assign rtag = rd_pc_i[PC_W-1:IDX_W+2];
  assign widx = wr_pc_i[IDX_W+1:2];
  assign wtag = wr_pc_i[PC_W-1:IDX_W+2];

  assign rd_hit_o = valid_q[ridx] && (tag_q[ridx] == rtag);
  assign rd_ent_o = ent_q[ridx];
  assign wr_hit   = valid_q[widx] && (tag_q[widx] == wtag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ent_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_hit) begin
        ent_q[widx].last <= wr_taken_i;
        if (wr_taken_i) begin
          ent_q[widx].target <= wr_target_i;
          ent_q[widx].bwd    <= (wr_target_i < wr_pc_i);
        end
      end else if (wr_taken_i) begin
        // allocate / replace; hint captured once here
        valid_q[widx]      <= 1'b1;
        tag_q[widx]        <= wtag;
        ent_q[widx].target <= wr_target_i;
        ent_q[widx].bwd    <= (wr_target_i < wr_pc_i);
        ent_q[widx].hint   <= wr_hint_i;
        ent_q[widx].last   <= 1'b1;
      end
    end
  end

  // R7
  nt_no_install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_taken_i) |=> $stable(valid_q));

  // R1
  idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q));
endmodule

// File: rtl/nfp_dir_sel.sv
module nfp_dir_sel import nfp_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic [2:0] mode_i,
  input  logic     hit_i,
  input  btb_ent_t ent_i,
  output logic     branch_o,
  output logic     taken_o
);
  dir_mode_e mode;
  assign mode = dir_mode_e'(mode_i);

  always_comb begin
    branch_o = hit_i;
    taken_o  = 1'b0;
    unique case (mode)
      M_ALWAYS: taken_o = hit_i;
      M_BACK:   taken_o = hit_i && ent_i.bwd;
      M_HINT:   taken_o = hit_i && ent_i.hint;
      M_LAST:   taken_o = hit_i && ent_i.last;
      default:  branch_o = 1'b0;
    endcase
  end

  // R1
  taken_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> hit_i);
endmodule

// File: rtl/nfp_mispredict.sv
module nfp_mispredict import nfp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_pred_pc_i,
  output logic            mispredict_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PC_W-1:0] actual_pc;
  logic            miss;

  assign actual_pc = res_taken_i ? res_target_i : res_pc_i + PC_W'(4);
  assign miss      = res_valid_i && (actual_pc != res_pred_pc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mispredict_o <= 1'b0;
      cnt_o        <= '0;
    end else begin
      mispredict_o <= miss;
      if (miss && cnt_o != '1) cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // R10
  no_res_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !mispredict_o);

  // R11
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> (cnt_o == $past(cnt_o) + CNT_W'(1)) ||
                     (cnt_o == '1 && $past(cnt_o) == '1));

  // R11
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mispredict_o |-> $stable(cnt_o));
endmodule

// File: rtl/nfp_predictor.sv
module nfp_predictor import nfp_pkg::*; #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic [PC_W-1:0]  pred_pc_o,
  output logic             pred_branch_o,
  output logic             pred_taken_o,
  input  logic             res_valid_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic [PC_W-1:0]  res_target_i,
  input  logic             res_taken_i,
  input  logic             res_hint_i,
  input  logic [PC_W-1:0]  res_pred_pc_i,
  output logic             mispredict_o,
  output logic [CNT_W-1:0] mispred_cnt_o
);
  logic     hit;
  btb_ent_t ent;

  nfp_btb #(.IDX_W(IDX_W)) u_btb (
    .clk_i, .rst_ni,
    .rd_pc_i(fetch_pc_i), .rd_hit_o(hit), .rd_ent_o(ent),
    .wr_en_i(res_valid_i), .wr_pc_i(res_pc_i), .wr_target_i(res_target_i),
    .wr_taken_i(res_taken_i), .wr_hint_i(res_hint_i)
  );

  nfp_dir_sel u_dir (
    .clk_i, .rst_ni, .mode_i, .hit_i(hit), .ent_i(ent),
    .branch_o(pred_branch_o), .taken_o(pred_taken_o)
  );

  nfp_mispredict #(.CNT_W(CNT_W)) u_mis (
    .clk_i, .rst_ni, .res_valid_i, .res_pc_i, .res_target_i, .res_taken_i,
    .res_pred_pc_i, .mispredict_o, .cnt_o(mispred_cnt_o)
  );

  assign pred_pc_o = pred_taken_o ? ent.target : fetch_pc_i + PC_W'(4);

  // R2
  never_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |-> (!pred_branch_o && !pred_taken_o));
endmodule

// File: tb/sim_nfp_predictor.sv
module sim_nfp_predictor;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic [2:0]  mode_i = 0;
  logic [31:0] fetch_pc_i = 0;
  logic [31:0] pred_pc_o;
  logic        pred_branch_o, pred_taken_o;
  logic        res_valid_i = 0;
  logic [31:0] res_pc_i = 0, res_target_i = 0, res_pred_pc_i = 0;
  logic        res_taken_i = 0, res_hint_i = 0;
  logic        mispredict_o;
  logic [15:0] mispred_cnt_o;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nfp_predictor u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [2:0] m, logic [31:0] pc,
                      logic [31:0] epc, logic eb, logic et);
    mode_i = m; fetch_pc_i = pc; #1;
    chk(req, pred_pc_o, epc);
    chk(req, {31'd0, pred_branch_o}, {31'd0, eb});
    chk(req, {31'd0, pred_taken_o}, {31'd0, et});
  endtask

  task automatic res(logic [31:0] pc, logic [31:0] tg, logic tk, logic hn,
                     logic [31:0] ppc);
    logic em;
    em = ((tk ? tg : pc + 4) != ppc);
    @(negedge clk_i);
    res_valid_i = 1; res_pc_i = pc; res_target_i = tg;
    res_taken_i = tk; res_hint_i = hn; res_pred_pc_i = ppc;
    @(negedge clk_i);
    res_valid_i = 0;
    if (em && exp_cnt < 65535) exp_cnt++;
    chk("R10 pulse", {31'd0, mispredict_o}, {31'd0, em});
    chk("R11 count", {16'd0, mispred_cnt_o}, exp_cnt);
  endtask

  function automatic logic [31:0] bpc(int i);  return 32'h1000 + i*4; endfunction
  function automatic logic [31:0] btg(int i);
    return (i % 2 == 0) ? bpc(i) - 32'h40 : bpc(i) + 32'h100;
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic last_dir;
    logic [31:0] epc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R11 reset count", {16'd0, mispred_cnt_o}, 0);
    chk("R10 reset pulse", {31'd0, mispredict_o}, 0);

    // R1: empty buffer, every mode
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 5; m++)
        look("R1 miss after reset", 3'(m), bpc(i), bpc(i) + 4, 0, 0);

    // R8: allocate all entries (predicted fall-through -> mispredicts)
    for (int i = 0; i < 16; i++) res(bpc(i), btg(i), 1, i[1], bpc(i) + 4);

    // R2..R6 sweep over modes and entries
    for (int i = 0; i < 16; i++) begin
      look("R2 never mode", 3'd0, bpc(i), bpc(i) + 4, 0, 0);
      look("R2 unused code", 3'd6, bpc(i), bpc(i) + 4, 0, 0);
      look("R3 always mode", 3'd1, bpc(i), btg(i), 1, 1);
      look("R4 backward mode", 3'd2, bpc(i), (i % 2 == 0) ? btg(i) : bpc(i) + 4, 1, i % 2 == 0);
      look("R5 hint mode", 3'd3, bpc(i), i[1] ? btg(i) : bpc(i) + 4, 1, i[1]);
      look("R6 last mode", 3'd4, bpc(i), btg(i), 1, 1);
    end

    // R7: not-taken miss aliasing index 0
    res(32'h2000, 32'h2100, 0, 1, 32'h2004);
    look("R7 not installed", 3'd1, 32'h2000, 32'h2004, 0, 0);
    look("R7 neighbour kept", 3'd1, bpc(0), btg(0), 1, 1);

    // R6: alternating outcomes on entry 0 all mispredict
    last_dir = 1;
    for (int k = 0; k < 10; k++) begin
      epc = last_dir ? btg(0) : bpc(0) + 4;
      look("R6 last pred", 3'd4, bpc(0), epc, 1, last_dir);
      res(bpc(0), btg(0), ~last_dir, 0, epc);
      chk("R6 alternating mispredict", {31'd0, mispredict_o}, 1);
      last_dir = ~last_dir;
    end

    // R5: not-taken resolve with hint 0 on entry 2 leaves hint at 1
    res(bpc(2), btg(2), 0, 0, btg(2));
    look("R5 hint kept", 3'd3, bpc(2), btg(2), 1, 1);
    look("R6 last updated", 3'd4, bpc(2), bpc(2) + 4, 1, 0);

    // R8: replace index 0 with a new tag
    res(32'h3000, 32'h3100, 1, 0, 32'h3004);
    look("R8 old evicted", 3'd1, bpc(0), bpc(0) + 4, 0, 0);
    look("R8 new entry", 3'd1, 32'h3000, 32'h3100, 1, 1);
    look("R8 new last taken", 3'd4, 32'h3000, 32'h3100, 1, 1);
    look("R4 forward", 3'd2, 32'h3000, 32'h3004, 1, 0);

    // R9: taken hit rewrites target and backward bit
    res(32'h3000, 32'h2F00, 1, 1, 32'h3100);
    look("R9 new target", 3'd2, 32'h3000, 32'h2F00, 1, 1);
    look("R9 hint unchanged", 3'd3, 32'h3000, 32'h3004, 1, 0);

    // R12: same-cycle update and lookup
    @(negedge clk_i);
    mode_i = 3'd1; fetch_pc_i = 32'h3000;
    res_valid_i = 1; res_pc_i = 32'h3000; res_target_i = 32'h3200;
    res_taken_i = 1; res_hint_i = 0; res_pred_pc_i = 32'h3200;
    #1;
    chk("R12 old contents", pred_pc_o, 32'h2F00);
    @(negedge clk_i);
    res_valid_i = 0; #1;
    chk("R12 new contents", pred_pc_o, 32'h3200);
    chk("R10 correct no pulse", {31'd0, mispredict_o}, 0);

    // R11: saturation with a held stream of wrong not-taken misses
    @(negedge clk_i);
    res_valid_i = 1; res_pc_i = 32'h4000; res_target_i = 32'h4100;
    res_taken_i = 0; res_pred_pc_i = 32'h4100;
    repeat (65540) @(negedge clk_i);
    res_valid_i = 0;
    exp_cnt = 65535;
    chk("R11 saturated", {16'd0, mispred_cnt_o}, 65535);
    chk("R10 pulse in burst", {31'd0, mispredict_o}, 1);
    @(negedge clk_i);
    chk("R10 pulse ends", {31'd0, mispredict_o}, 0);
    chk("R11 held", {16'd0, mispred_cnt_o}, 65535);
    look("R7 burst not installed", 3'd1, 32'h4000, 32'h4004, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule